// File: doc/BRIEF.md
# Opcode-menu SPI flash cycle engine

This block lets a host run single commands on a serial flash device through a small register file. Commands are not free-form. The host fills an eight-entry opcode menu and gives each entry a 2-bit type code, which decides whether an address phase goes out and which way data moves. It also loads a 24-bit address, a 64-byte data buffer and an optional prefix opcode. It then writes a control word that names a menu entry, a byte count and a data-phase flag, with the go bit set. The engine drives chip select, serial clock and MOSI in SPI mode 0, samples MISO, and reports completion or error through status bits that the host clears by writing 1.

A prefix opcode, typically a write enable, can be chained ahead of the main command as its own chip-select frame. Nothing else can reach the bus between the two frames. A lock bit, once set, freezes the menu, the type register and the prefix register until reset. Addresses whose data phase would run past the top of the 24-bit space are refused before the bus is touched.

The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure: writes are always accepted, and a go request that arrives while a cycle is running is simply dropped. The serial pins carry no handshake beyond chip select.

Top module: `spi_menu_engine`

## Requirements
- R1: After reset the status register (offset 0) reads 0, chip select is high and the serial clock is low.
- R2: SPI mode 0. The clock idles low, with CLK_DIV system cycles per half period. MOSI sends bytes most significant bit first. Chip select stays low across the opcode, address and data of one frame.
- R3: Control bits [6:4] pick menu entry n. Entry n is byte n%4 of offset 5 (n<4) or offset 6 (n>=4), and it is the first byte of the main frame. Its type is bits [2n+1:2n] of offset 4: 0 read without address, 1 write without address, 2 read with address, 3 write with address.
- R4: For types 2 and 3, three address bytes follow the opcode, taken from the low 24 bits of offset 2, most significant byte first.
- R5: With control bit 14 set, (bits [13:8])+1 data bytes follow the header. Write types send buffer bytes. Read types store the received bytes. Buffer byte k lives in word k/4 (offset 16+k/4) at bits [8(k%4)+7:8(k%4)], and byte 0 is the first data byte.
- R6: A command of type 0 or 1 with bit 14 clear sends only the opcode byte, then raises done.
- R7: With control bit 3 set, the prefix opcode (offset 3) goes out as a one-byte frame. Chip select then rises for one clock period, and the main frame follows before done is raised.
- R8: Status bit 0 (busy) is high from the go write until the last chip-select rise. At that rise bit 1 (done) is set. Writing 1 clears bit 1 and bit 2 (error); writing 0 has no effect.
- R9: A control write with the go bit (bit 1) while busy is ignored: no new frame, and the control readback keeps the running command.
- R10: A go with bit 14 set on a type 2 or 3 entry, where address + byte count exceeds 2^24, sets the error bit and drives no frame. Landing exactly on 2^24 is allowed.
- R11: Writing 1 to status bit 15 sets a lock that reads back in bit 15 until reset. While it is set, writes to offsets 3, 4, 5 and 6 are ignored; address, buffer and control writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A go write that lands while a command is still running is the hardest case to reach from the ports, because the window is only open while busy is high. The bench issues a second go write in the register cycle right after the first, then counts chip-select frames and reads back the control word. The range check is reached by loading an address just below the top of the 24-bit space. Byte counts are then chosen to land exactly on the limit and one past it. The menu is swept over all eight entries, every type code, counts of 1, 5 and 64, and with and without the prefix.

// File: rtl/spi_menu_pkg.sv
package spi_menu_pkg;
  // register word offsets
  localparam logic [4:0] OFS_STAT = 5'd0;
  localparam logic [4:0] OFS_CTRL = 5'd1;
  localparam logic [4:0] OFS_ADDR = 5'd2;
  localparam logic [4:0] OFS_PREF = 5'd3;
  localparam logic [4:0] OFS_TYPE = 5'd4;
  localparam logic [4:0] OFS_MLO  = 5'd5;
  localparam logic [4:0] OFS_MHI  = 5'd6;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PRE, SQ_GAP, SQ_OPC, SQ_ADR, SQ_DAT, SQ_TAIL
  } seq_st_e;
endpackage

// File: rtl/spi_menu_shifter.sv
module spi_menu_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          act_q, sclk_q, done_q;
  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      div_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q <= 1'b1; tx_q <= tx_byte; bit_q <= '0; div_q <= '0;
        end
      end else if (div_q == CW'(DIV - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= {tx_q[6:0], 1'b0};
          bit_q  <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];

  // R2: the sequencer never launches a byte over one in flight
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);
  // R2: a clock edge only appears while a byte is shifting
  a_r2_clock_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(act_q));
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
  import spi_menu_pkg::*;
#(
  parameter int DIV  = 2,
  parameter int BI_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            pre_en,
  input  logic [7:0]      pre_op,
  input  logic [7:0]      opcode,
  input  logic [1:0]      otype,
  input  logic [23:0]     addr,
  input  logic            dat_en,
  input  logic [BI_W-1:0] last_idx,
  input  logic            sh_done,
  input  logic [7:0]      rx_byte,
  input  logic [7:0]      buf_byte,
  output logic            sh_start,
  output logic [7:0]      sh_tx,
  output logic            cs_n,
  output logic [BI_W-1:0] byte_idx,
  output logic            wr_en,
  output logic [7:0]      wr_byte,
  output logic            finish
);
  localparam int GAP_LAST = 2 * DIV - 1;
  localparam int GW       = $clog2(2 * DIV + 1);

  seq_st_e         st_q;
  logic            pend_q, cs_q, fin_q, pre_q_en, dat_q;
  logic [7:0]      pre_q, op_q;
  logic [1:0]      ty_q, ab_q;
  logic [23:0]     ad_q;
  logic [BI_W-1:0] idx_q, last_q;
  logic [GW-1:0]   gcnt_q;

  always_comb begin
    unique case (st_q)
      SQ_PRE:  sh_tx = pre_q;
      SQ_OPC:  sh_tx = op_q;
      SQ_ADR:  sh_tx = (ab_q == 2'd0) ? ad_q[23:16] :
                       (ab_q == 2'd1) ? ad_q[15:8] : ad_q[7:0];
      SQ_DAT:  sh_tx = ty_q[0] ? buf_byte : 8'h00;
      default: sh_tx = 8'h00;
    endcase
  end

  assign sh_start = pend_q;
  assign cs_n     = cs_q;
  assign finish   = fin_q;
  assign byte_idx = idx_q;
  assign wr_en    = (st_q == SQ_DAT) && sh_done && !ty_q[0];
  assign wr_byte  = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; pend_q <= 1'b0; cs_q <= 1'b1; fin_q <= 1'b0;
      pre_q_en <= 1'b0; dat_q <= 1'b0; pre_q <= '0; op_q <= '0;
      ty_q <= '0; ab_q <= '0; ad_q <= '0; idx_q <= '0; last_q <= '0;
      gcnt_q <= '0;
    end else begin
      pend_q <= 1'b0;
      fin_q  <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (go) begin
          pre_q_en <= pre_en; pre_q <= pre_op; op_q <= opcode; ty_q <= otype;
          ad_q <= addr; dat_q <= dat_en; last_q <= last_idx;
          cs_q <= 1'b0; pend_q <= 1'b1;
          st_q <= pre_en ? SQ_PRE : SQ_OPC;
        end
        SQ_PRE: if (sh_done) begin
          cs_q <= 1'b1; gcnt_q <= '0; st_q <= SQ_GAP;
        end
        SQ_GAP: if (gcnt_q == GW'(GAP_LAST)) begin
          cs_q <= 1'b0; pend_q <= 1'b1; st_q <= SQ_OPC;
        end else gcnt_q <= gcnt_q + GW'(1);
        SQ_OPC: if (sh_done) begin
          if (ty_q[1]) begin
            st_q <= SQ_ADR; ab_q <= '0; pend_q <= 1'b1;
          end else if (dat_q) begin
            st_q <= SQ_DAT; idx_q <= '0; pend_q <= 1'b1;
          end else begin
            st_q <= SQ_TAIL; gcnt_q <= '0;
          end
        end
        SQ_ADR: if (sh_done) begin
          if (ab_q != 2'd2) begin
            ab_q <= ab_q + 2'd1; pend_q <= 1'b1;
          end else if (dat_q) begin
            st_q <= SQ_DAT; idx_q <= '0; pend_q <= 1'b1;
          end else begin
            st_q <= SQ_TAIL; gcnt_q <= '0;
          end
        end
        SQ_DAT: if (sh_done) begin
          if (idx_q == last_q) begin
            st_q <= SQ_TAIL; gcnt_q <= '0;
          end else begin
            idx_q <= idx_q + BI_W'(1); pend_q <= 1'b1;
          end
        end
        SQ_TAIL: if (gcnt_q == GW'(GAP_LAST)) begin
          cs_q <= 1'b1; fin_q <= 1'b1; st_q <= SQ_IDLE;
        end else gcnt_q <= gcnt_q + GW'(1);
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R7: the frame between prefix and main command keeps chip select high
  a_r7_gap_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_GAP) |-> cs_n);
endmodule

// File: rtl/spi_menu_engine.sv
module spi_menu_engine
  import spi_menu_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int BUF_WORDS = 16,
  parameter int MENU_N    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int BI_W = $clog2(BUF_WORDS * 4);
  localparam int BW_W = $clog2(BUF_WORDS);
  localparam int MI_W = $clog2(MENU_N);

  logic busy_q, done_q, err_q, lock_q;
  logic pre_q, dat_q;
  logic [MI_W-1:0] idx_q;
  logic [BI_W-1:0] cnt_q;
  logic [23:0] addr_q;
  logic [7:0]  preop_q;
  logic [15:0] types_q;
  logic [7:0]  menu_q [MENU_N];
  logic [31:0] buf_q  [BUF_WORDS];

  // control-word decode
  logic            wr_stat, wr_ctrl, go_req, go_ok, range_bad, seq_go;
  logic [MI_W-1:0] sel_idx;
  logic [1:0]      sel_ty;
  logic [BI_W-1:0] sel_last;
  logic [24:0]     span_end;

  assign wr_stat  = reg_we && (reg_addr == OFS_STAT);
  assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
  assign go_req   = wr_ctrl && reg_wdata[1];
  assign go_ok    = go_req && !busy_q;
  assign sel_idx  = reg_wdata[4 +: MI_W];
  assign sel_ty   = types_q[{sel_idx, 1'b0} +: 2];
  assign sel_last = reg_wdata[8 +: BI_W];
  assign span_end = {1'b0, addr_q} + 25'(sel_last) + 25'd1;
  assign range_bad = reg_wdata[14] && sel_ty[1] && (span_end > 25'h100_0000);
  assign seq_go   = go_ok && !range_bad;

  // sequencer and shifter
  logic            sh_start, sh_done, seq_wr, seq_fin;
  logic [7:0]      sh_tx, rx_byte, wr_byte, buf_byte;
  logic [BI_W-1:0] byte_idx;

  assign buf_byte = buf_q[byte_idx[BI_W-1:2]][{byte_idx[1:0], 3'b000} +: 8];

  spi_menu_seq #(.DIV(CLK_DIV), .BI_W(BI_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(seq_go), .pre_en(reg_wdata[3]),
    .pre_op(preop_q), .opcode(menu_q[sel_idx]), .otype(sel_ty),
    .addr(addr_q), .dat_en(reg_wdata[14]), .last_idx(sel_last),
    .sh_done(sh_done), .rx_byte(rx_byte), .buf_byte(buf_byte),
    .sh_start(sh_start), .sh_tx(sh_tx), .cs_n(spi_cs_n),
    .byte_idx(byte_idx), .wr_en(seq_wr), .wr_byte(wr_byte), .finish(seq_fin)
  );

  spi_menu_shifter #(.DIV(CLK_DIV)) shf_i (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
    .miso(spi_miso), .done(sh_done), .rx_byte(rx_byte),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  // status and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
      pre_q <= 1'b0; dat_q <= 1'b0; idx_q <= '0; cnt_q <= '0;
      addr_q <= '0; preop_q <= '0; types_q <= '0;
      for (int i = 0; i < MENU_N; i++) menu_q[i] <= '0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[1])  done_q <= 1'b0;
        if (reg_wdata[2])  err_q  <= 1'b0;
        if (reg_wdata[15]) lock_q <= 1'b1;
      end
      if (wr_ctrl && !busy_q) begin
        pre_q <= reg_wdata[3]; dat_q <= reg_wdata[14];
        idx_q <= sel_idx; cnt_q <= sel_last;
      end
      if (seq_go) busy_q <= 1'b1;
      if (go_ok && range_bad) err_q <= 1'b1;
      if (seq_fin) begin
        busy_q <= 1'b0; done_q <= 1'b1;
      end
      if (reg_we && reg_addr == OFS_ADDR) addr_q <= reg_wdata[23:0];
      if (!lock_q && reg_we) begin
        if (reg_addr == OFS_PREF) preop_q <= reg_wdata[7:0];
        if (reg_addr == OFS_TYPE) types_q <= reg_wdata[15:0];
        if (reg_addr == OFS_MLO)
          for (int i = 0; i < MENU_N / 2; i++) menu_q[i] <= reg_wdata[8*i +: 8];
        if (reg_addr == OFS_MHI)
          for (int i = 0; i < MENU_N / 2; i++) menu_q[i + MENU_N/2] <= reg_wdata[8*i +: 8];
      end
    end
  end

  // data buffer: the engine's receive writes take priority over the host
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < BUF_WORDS; w++) buf_q[w] <= '0;
    end else if (seq_wr) begin
      buf_q[byte_idx[BI_W-1:2]][{byte_idx[1:0], 3'b000} +: 8] <= wr_byte;
    end else if (reg_we && reg_addr[4]) begin
      buf_q[reg_addr[BW_W-1:0]] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STAT: reg_rdata = {16'd0, lock_q, 12'd0, err_q, done_q, busy_q};
      OFS_CTRL: reg_rdata = {17'd0, dat_q, 8'(cnt_q), 1'b0, 3'(idx_q), pre_q, 3'd0};
      OFS_ADDR: reg_rdata = {8'd0, addr_q};
      OFS_PREF: reg_rdata = {24'd0, preop_q};
      OFS_TYPE: reg_rdata = {16'd0, types_q};
      OFS_MLO:  reg_rdata = {menu_q[3], menu_q[2], menu_q[1], menu_q[0]};
      OFS_MHI:  reg_rdata = {menu_q[7], menu_q[6], menu_q[5], menu_q[4]};
      default:  if (reg_addr[4]) reg_rdata = buf_q[reg_addr[BW_W-1:0]];
    endcase
  end

  // R8: the bus is only selected while a command is running
  a_r8_select_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy_q);
  // R2: the clock rests low whenever the device is deselected
  a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R9: a go during a running command neither ends nor replaces it
  a_r9_busy_go_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && go_req && !seq_fin) |=> (busy_q && $stable(idx_q)));
  // R10: a refused command leaves the bus deselected
  a_r10_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ok && range_bad) |=> (spi_cs_n && !busy_q));
  // R11: lock holds until reset and freezes the menu
  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r11_menu_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && reg_we && reg_addr == OFS_MLO) |=> $stable(menu_q[0]));
endmodule

// File: tb/spi_menu_engine_tb_top.sv
module spi_menu_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_menu_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int nvec = 0, nfail = 0;
  bit finished = 1'b0;

  // ---------------- flash-side model: logs frames, answers with a pattern
  logic [7:0] mlog [0:4095];
  int fstart [0:511];
  int flen   [0:511];
  int nframes = 0, nlog = 0, bit_i = 0, bif = 0;
  logic [7:0] sh_in = '0;
  realtime last_rise = 0, period = 0;

  function automatic logic [7:0] pat(input int n);
    return 8'(n * 37 + 11);
  endfunction

  always @(negedge spi_cs_n) begin
    fstart[nframes] = nlog; bit_i = 0; bif = 0;
    spi_miso = pat(0)[7];
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    flen[nframes] = nlog - fstart[nframes];
    nframes++;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (bit_i > 0) period = $realtime - last_rise;
    last_rise = $realtime;
    sh_in = {sh_in[6:0], spi_mosi};
    bit_i++;
    if (bit_i == 8) begin
      mlog[nlog] = sh_in; nlog++; bit_i = 0; bif++;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = pat(bif)[7 - bit_i];

  // ---------------- helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'd1;
    while (s[0]) rd(5'd0, s);
  endtask

  function automatic logic [7:0] opc(input int i);
    return 8'(8'h21 + i * 8'h13);
  endfunction
  function automatic logic [7:0] wbyte(input int i, input int k);
    return 8'(i * 29 + k * 13 + 1);
  endfunction
  function automatic logic [31:0] ctl(input int i, input bit pre, input bit dat, input int cnt);
    return (32'(dat) << 14) | (32'(cnt - 1) << 8) | (32'(i) << 4) | (32'(pre) << 3) | 32'h2;
  endfunction

  // one full command; menu entry i has opcode opc(i) and type i%4
  task automatic run(input int i, input bit pre, input bit dat, input int cnt,
                     input logic [23:0] a, input logic [7:0] pop);
    logic [31:0] s, w;
    int f0, m, ty, hdr, elen;
    ty = i % 4;
    wr(5'd2, {8'd0, a});
    if (ty[0] && dat)
      for (int q = 0; q < 16; q++)
        wr(5'(16 + q), {wbyte(i, 4*q+3), wbyte(i, 4*q+2), wbyte(i, 4*q+1), wbyte(i, 4*q)});
    f0 = nframes;
    wr(5'd1, ctl(i, pre, dat, cnt));
    rd(5'd0, s);
    chk("R8 busy after go", {31'd0, s[0]}, 32'd1);
    wait_idle();
    rd(5'd0, s);
    chk("R8 done at end", s & 32'h7, 32'h2);
    wr(5'd0, 32'h2);
    rd(5'd0, s);
    chk("R8 done cleared by 1", s & 32'h7, 32'h0);
    chk("R7 frame count", 32'(nframes - f0), pre ? 32'd2 : 32'd1);
    if (pre) begin
      chk("R7 prefix frame length", 32'(flen[f0]), 32'd1);
      chk("R7 prefix opcode", {24'd0, mlog[fstart[f0]]}, {24'd0, pop});
    end
    m = pre ? f0 + 1 : f0;
    hdr = (ty >= 2) ? 4 : 1;
    elen = hdr + (dat ? cnt : 0);
    chk((!dat && ty < 2) ? "R6 opcode-only length" : "R2 frame length", 32'(flen[m]), 32'(elen));
    chk("R3 opcode", {24'd0, mlog[fstart[m]]}, {24'd0, opc(i)});
    if (ty >= 2) begin
      chk("R4 addr hi",  {24'd0, mlog[fstart[m]+1]}, {24'd0, a[23:16]});
      chk("R4 addr mid", {24'd0, mlog[fstart[m]+2]}, {24'd0, a[15:8]});
      chk("R4 addr lo",  {24'd0, mlog[fstart[m]+3]}, {24'd0, a[7:0]});
    end
    if (dat) begin
      for (int k = 0; k < cnt; k++) begin
        if (ty[0]) chk("R5 write byte", {24'd0, mlog[fstart[m]+hdr+k]}, {24'd0, wbyte(i, k)});
        else begin
          rd(5'(16 + k/4), w);
          chk("R5 read byte", {24'd0, w[8*(k%4) +: 8]}, {24'd0, pat(hdr + k)});
        end
      end
    end
  endtask

  // ---------------- main sequence
  initial begin
    logic [31:0] s;
    int f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(5'd0, s);
    chk("R1 status after reset", s, 32'd0);
    chk("R1 chip select idle", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 clock idle", {31'd0, spi_sclk}, 32'd0);

    wr(5'd4, 32'h0000_E4E4);
    wr(5'd5, {opc(3), opc(2), opc(1), opc(0)});
    wr(5'd6, {opc(7), opc(6), opc(5), opc(4)});
    wr(5'd3, 32'h06);

    // sweep every entry, several counts, prefix on and off
    for (int i = 0; i < 8; i++) begin
      run(i, 1'b0, 1'b1, 1,  24'h120000 + 24'(i * 257), 8'h06);
      run(i, 1'b1, 1'b1, 5,  24'h340000 + 24'(i * 257), 8'h06);
      run(i, i[0], 1'b1, 64, 24'h560000 + 24'(i * 257), 8'h06);
      run(i, 1'b0, 1'b0, 1,  24'hABCDEF - 24'(i), 8'h06);
    end
    chk("R2 clock period ns", 32'(int'(period)), 32'd16);

    // R9: go while busy is dropped
    f0 = nframes;
    wr(5'd2, 32'h00_1000);
    wr(5'd1, ctl(2, 1'b0, 1'b1, 8));
    wr(5'd1, ctl(5, 1'b1, 1'b0, 1));
    rd(5'd1, s);
    chk("R9 control keeps running entry", 32'(s[6:4]), 32'd2);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R9 single frame", 32'(nframes - f0), 32'd1);
    chk("R9 opcode of first go", {24'd0, mlog[fstart[f0]]}, {24'd0, opc(2)});
    rd(5'd0, s);
    chk("R8 done set", s & 32'h7, 32'h2);
    wr(5'd0, 32'h0);
    rd(5'd0, s);
    chk("R8 write 0 keeps done", s & 32'h7, 32'h2);
    wr(5'd0, 32'h2);

    // R10: range limit at the top of the address space
    f0 = nframes;
    wr(5'd2, 32'hFF_FFF0);
    wr(5'd1, ctl(2, 1'b0, 1'b1, 17));
    repeat (40) @(negedge clk);
    rd(5'd0, s);
    chk("R10 error set", s & 32'h7, 32'h4);
    chk("R10 no frame", 32'(nframes - f0), 32'd0);
    wr(5'd0, 32'h4);
    rd(5'd0, s);
    chk("R8 error cleared by 1", s & 32'h7, 32'h0);
    run(2, 1'b0, 1'b1, 16, 24'hFFFFF0, 8'h06);
    rd(5'd0, s);
    chk("R10 exact end accepted", s & 32'h4, 32'h0);
    run(0, 1'b0, 1'b1, 64, 24'hFFFFF0, 8'h06);

    // R11: lock freezes menu, type and prefix
    wr(5'd0, 32'h8000);
    rd(5'd0, s);
    chk("R11 lock reads back", s, 32'h8000);
    wr(5'd5, 32'h0);
    wr(5'd4, 32'h0);
    wr(5'd3, 32'h77);
    rd(5'd5, s);
    chk("R11 menu frozen", s, {opc(3), opc(2), opc(1), opc(0)});
    rd(5'd4, s);
    chk("R11 types frozen", s, 32'h0000_E4E4);
    rd(5'd3, s);
    chk("R11 prefix frozen", s, 32'h06);
    run(3, 1'b1, 1'b1, 5, 24'h0A0B0C, 8'h06);
    rd(5'd2, s);
    chk("R11 address still writable", s, 32'h0A0B0C);
    wr(5'd0, 32'h2);
    rd(5'd0, s);
    chk("R11 lock survives clear", s & 32'h8000, 32'h8000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(5'd0, s);
    chk("R11 lock cleared by reset", s, 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nvec++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule